// File: doc/BRIEF.md
# Infrared Serial Line Encoder/Decoder

This block sits between a UART's serial bit streams and the line pins. In wired mode it passes the transmit bit straight to the line and returns the synchronised line input as the receive bit. In infrared mode it turns every transmitted zero into a short pulse of 3/16 of a bit cell, centred in the cell, and sends nothing for a one. Short pulses arriving on the line are stretched back into NRZ zeros for the UART receiver. Timing comes from the UART's oversampling tick (`tick_en`, `OSR` ticks per bit, 16 by default, 8 also supported). The block has no access to the UART's framing. It finds bit cells by resynchronising a phase counter on every change of the transmit bit.

The line idles high in wired mode. In infrared mode the transmit pin idles low, and the receive pin idles at a level chosen by `rx_pol`. The infrared mode is taken from the `ir_strap` input on hardware reset and on `soft_rst`. After that, software can request a new mode with `ir_wr`. A requested change is applied only when the line is quiet, so a character in flight is never cut.

Top module: `irda_endec`

## Requirements
- R1: In wired mode `line_tx` equals `uart_tx_bit` in the same cycle, and `uart_rx_bit` equals `line_rx` as it was two clock edges earlier.
- R2: In infrared mode `line_tx` is low while no zero bit is being sent.
- R3: In infrared mode a bit cell starts at the first tick that sees a new value on `uart_tx_bit`, and its phase then counts 0 to OSR-1 per tick and wraps. For a 0 bit, `line_tx` goes high after the ticks of phases 7, 8 and 9 (3 ticks of 16) and is low after every other tick.
- R4: In infrared mode a 1 bit produces no pulse on `line_tx`.
- R5: With `rx_pol`=0 the infrared receive line idles low and a high level is a pulse. Each tick that sees a pulse on the synchronised line (two flops) makes `uart_rx_bit` 0, and it stays 0 for OSR ticks after the last such tick. A looped-back byte is recovered exactly.
- R6: With `rx_pol`=1 the infrared receive line idles high and a low level is a pulse. It is otherwise decoded as in R5.
- R7: In infrared mode, with no pulse on the receive line, `uart_rx_bit` is held at 1.
- R8: Hardware reset (`rst_n` low at a clock edge) loads the mode from `ir_strap` (1 = infrared).
- R9: A `soft_rst` pulse reloads both the active and the requested mode from `ir_strap` on the next edge, whatever the line is doing.
- R10: An `ir_wr` pulse requests mode `ir_wr_val`. The request takes effect one edge after the line is quiet: `uart_tx_bit` high for OSR*IDLE_BITS consecutive ticks and no received zero being held. Until then the old mode stays in force.
- R11: Clock cycles without `tick_en` do not advance the encoder or the decoder, so pulse widths and hold times are counted in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Oversampling tick, OSR per bit |
| uart_tx_bit | input | 1 | Serial transmit bit from the UART |
| line_rx | input | 1 | Raw receive line pin |
| ir_strap | input | 1 | Mode strap sampled on hardware and soft reset |
| soft_rst | input | 1 | Soft reset pulse, reloads mode from strap |
| ir_wr | input | 1 | Software mode write strobe |
| ir_wr_val | input | 1 | Requested mode (1 = infrared) |
| rx_pol | input | 1 | Infrared receive polarity (0: high pulses, 1: low pulses) |
| line_tx | output | 1 | Transmit line pin |
| uart_rx_bit | output | 1 | Recovered receive bit to the UART |

## Verification
The bench loops the line back and sends bytes dense in zeros, dense in ones, and in alternating patterns, under both polarities and with gapped ticks. An encoder with an off-by-one phase would show pulses of the wrong width or off centre. A decoder with a short stretcher would split runs of zeros or drop isolated ones. A mode write lands in the middle of a frame, where a design that switched at once would flip the idle level of a one bit. The switch back into infrared mode exposes a decoder that treats the change of line idle level as a pulse. Soft reset and hardware reset with the strap set exercise the mode load paths.

// File: rtl/irda_pkg.sv
package irda_pkg;
    // Number of ticks a transmit pulse lasts: 3/16 of a bit cell, rounded.
    function automatic int pulse_ticks(input int osr);
        return (3 * osr + 8) / 16;
    endfunction

    // First phase of the pulse so that it sits in the middle of the cell.
    function automatic int pulse_start(input int osr);
        return osr / 2 - pulse_ticks(osr) / 2;
    endfunction
endpackage

// File: rtl/irda_mode_ctrl.sv
// Mode control: holds the requested and the active infrared mode.
// Assumes: strap is static around reset; tick_en is the UART oversampling tick.
// The request is loaded from the strap on reset and soft reset, or written by software.
// The active mode follows the request only when the line has been quiet long enough.
module irda_mode_ctrl #(
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic tx_bit,
    input  logic dec_busy,
    input  logic strap_ir,
    input  logic soft_rst,
    input  logic sw_wr,
    input  logic sw_ir,
    output logic ir_mode
);
    localparam int IDLE_TICKS = OSR * IDLE_BITS;
    localparam int CW         = $clog2(IDLE_TICKS + 1);

    logic [CW-1:0] quiet_cnt_q;
    logic          req_q;
    logic          mode_q;
    logic          line_idle;

    // Count consecutive ticks with the transmit bit high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt_q <= '0;
        end else if (tick_en) begin
            if (!tx_bit)
                quiet_cnt_q <= '0;
            else if (quiet_cnt_q != CW'(IDLE_TICKS))
                quiet_cnt_q <= quiet_cnt_q + 1'b1;
        end
    end

    assign line_idle = (quiet_cnt_q == CW'(IDLE_TICKS)) && !dec_busy;

    // Requested mode: strap on reset and soft reset, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            req_q <= strap_ir;
        else if (sw_wr)
            req_q <= sw_ir;
    end

    // Active mode: strap on reset and soft reset, else the request at idle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            mode_q <= strap_ir;
        else if (line_idle)
            mode_q <= req_q;
    end

    assign ir_mode = mode_q;

    // R10: the mode only moves at a quiet line, on soft reset or out of reset.
    p_switch_at_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> ($past(line_idle) || $past(soft_rst) || !$past(rst_n)))
        else $error("mode changed while the line was busy");

    // R9: soft reset reloads the strap value.
    p_soft_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_q == $past(strap_ir)))
        else $error("soft reset did not load strap");
endmodule

// File: rtl/irda_pulse_enc.sv
// Transmit encoder: turns each zero bit into a centred pulse of 3/16 of a cell.
// Assumes: the UART changes its transmit bit only right after a tick, and holds
// each bit for OSR ticks. The cell phase resyncs on every change of the bit.
module irda_pulse_enc
    import irda_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic tx_bit,
    output logic pulse_out
);
    localparam int PW  = pulse_ticks(OSR);
    localparam int PS  = pulse_start(OSR);
    localparam int PHW = $clog2(OSR);

    logic [PHW-1:0] phase_q;
    logic [PHW-1:0] phase_d;
    logic           last_q;
    logic           pulse_q;
    logic           in_win;

    // Next cell phase: restart on a bit change, otherwise advance with wrap.
    always_comb begin
        if (tx_bit != last_q)
            phase_d = '0;
        else if (phase_q == PHW'(OSR - 1))
            phase_d = '0;
        else
            phase_d = phase_q + 1'b1;
    end

    assign in_win = (int'(phase_d) >= PS) && (int'(phase_d) < PS + PW);

    // Advance phase and produce the pulse level once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            last_q  <= 1'b1;
            pulse_q <= 1'b0;
        end else if (tick_en) begin
            phase_q <= phase_d;
            last_q  <= tx_bit;
            pulse_q <= !tx_bit && in_win;
        end
    end

    assign pulse_out = pulse_q;

    // R3: a pulse is only ever seen inside the centre window of the cell.
    p_pulse_centred_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> ((int'(phase_q) >= PS) && (int'(phase_q) < PS + PW)))
        else $error("pulse outside centre window");

    // R4: a tick that sees a one bit leaves no pulse behind.
    p_one_is_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && tx_bit) |=> !pulse_q)
        else $error("pulse for a one bit");
endmodule

// File: rtl/irda_pulse_dec.sv
// Receive decoder: synchronises the line, detects pulses of either polarity and
// stretches each into a zero lasting one bit cell of ticks.
// Assumes: rx_pol is static while infrared mode is active.
// On a mode change the synchroniser is reloaded with the new idle level, so the
// jump in line idle level is not taken for a pulse.
module irda_pulse_dec #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic ir_on,
    input  logic rx_pol,
    input  logic rst_lvl,
    input  logic line_rx,
    output logic rx_bit,
    output logic busy
);
    localparam int HW = $clog2(OSR + 1);

    logic          s1_q;
    logic          s2_q;
    logic          ir_prev_q;
    logic          mode_chg;
    logic          pulse;
    logic          idle_lvl;
    logic [HW-1:0] hold_q;

    assign mode_chg = (ir_on != ir_prev_q);
    assign idle_lvl = ir_on ? rx_pol : 1'b1;
    assign pulse    = s2_q ^ rx_pol;

    // Track the mode one cycle back to spot a change.
    always_ff @(posedge clk) begin
        ir_prev_q <= ir_on;
    end

    // Two-flop synchroniser, reloaded to the idle level on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= rst_lvl;
            s2_q <= rst_lvl;
        end else if (mode_chg) begin
            s1_q <= idle_lvl;
            s2_q <= idle_lvl;
        end else begin
            s1_q <= line_rx;
            s2_q <= s1_q;
        end
    end

    // Pulse stretcher: reload on a pulse tick, count down on quiet ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !ir_on || mode_chg)
            hold_q <= '0;
        else if (tick_en) begin
            if (pulse)
                hold_q <= HW'(OSR);
            else if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

    assign rx_bit = ir_on ? (hold_q == '0) : s2_q;
    assign busy   = (hold_q != '0);

    // R5: a pulse seen on a tick drives the receive bit to zero.
    p_pulse_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ir_on && !mode_chg && pulse) |=> (!rx_bit || !ir_on))
        else $error("pulse not decoded as zero");

    // R7: once the stretch runs out with no new pulse, the bit returns to one.
    p_quiet_is_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ir_on && !mode_chg && !pulse && (hold_q <= HW'(1))) |=> (rx_bit || !ir_on))
        else $error("receive bit not released to one");
endmodule

// File: rtl/irda_endec.sv
// Top level of the infrared serial line encoder/decoder.
// Assumes: one UART channel drives uart_tx_bit on the tick_en grid.
// In wired mode the bits pass through; in infrared mode transmit zeros become
// short pulses and received pulses are stretched back into zero bits.
module irda_endec #(
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic uart_tx_bit,
    input  logic line_rx,
    input  logic ir_strap,
    input  logic soft_rst,
    input  logic ir_wr,
    input  logic ir_wr_val,
    input  logic rx_pol,
    output logic line_tx,
    output logic uart_rx_bit
);
    logic ir_mode;
    logic enc_pulse;
    logic dec_busy;
    logic rst_lvl;

    assign rst_lvl = ir_strap ? rx_pol : 1'b1;

    irda_mode_ctrl #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .tx_bit   (uart_tx_bit),
        .dec_busy (dec_busy),
        .strap_ir (ir_strap),
        .soft_rst (soft_rst),
        .sw_wr    (ir_wr),
        .sw_ir    (ir_wr_val),
        .ir_mode  (ir_mode)
    );

    irda_pulse_enc #(.OSR(OSR)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .tx_bit    (uart_tx_bit),
        .pulse_out (enc_pulse)
    );

    irda_pulse_dec #(.OSR(OSR)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .ir_on   (ir_mode),
        .rx_pol  (rx_pol),
        .rst_lvl (rst_lvl),
        .line_rx (line_rx),
        .rx_bit  (uart_rx_bit),
        .busy    (dec_busy)
    );

    // Line transmit: encoded pulses in infrared mode, plain bit otherwise.
    assign line_tx = ir_mode ? enc_pulse : uart_tx_bit;
endmodule

// File: tb/irda_endec_tb_top.sv
module irda_endec_tb_top;
    localparam int OSR        = 16;
    localparam int IDLE_BITS  = 11;
    localparam int IDLE_TICKS = OSR * IDLE_BITS;
    localparam int PW         = 3;
    localparam int PSTART     = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic uart_tx_bit = 1'b1;
    logic ir_strap = 1'b0;
    logic soft_rst = 1'b0;
    logic ir_wr = 1'b0;
    logic ir_wr_val = 1'b0;
    logic rx_pol = 1'b0;
    logic rx_drv = 1'b1;
    logic loop_en = 1'b0;
    logic line_tx;
    logic uart_rx_bit;
    wire  line_rx = loop_en ? (line_tx ^ rx_pol) : rx_drv;

    int    n_chk = 0;
    int    n_fail = 0;
    int    gap = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    irda_endec #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .uart_tx_bit(uart_tx_bit),
        .line_rx(line_rx), .ir_strap(ir_strap), .soft_rst(soft_rst), .ir_wr(ir_wr),
        .ir_wr_val(ir_wr_val), .rx_pol(rx_pol), .line_tx(line_tx), .uart_rx_bit(uart_rx_bit)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_req = 0, m_mode = 0, m_prev = 0, m_phase = 0, m_last = 1, m_enc = 0;
    int m_idle = 0, m_hold = 0, m_s1 = 1, m_s2 = 1;
    int t_tx, t_rx, t_cur, t_li, t_chg, t_lvl, n_s1, n_s2, n_hold, n_mode, n_req;

    always @(posedge clk) begin
        t_chg = (m_mode != m_prev);
        m_prev = m_mode;
        if (!rst_n) begin
            m_req = ir_strap; m_mode = ir_strap;
            m_phase = 0; m_last = 1; m_enc = 0; m_idle = 0; m_hold = 0;
            m_s1 = ir_strap ? rx_pol : 1; m_s2 = m_s1;
        end else begin
            t_tx  = m_mode ? m_enc : uart_tx_bit;
            t_rx  = loop_en ? (t_tx ^ rx_pol) : rx_drv;
            t_li  = (m_idle == IDLE_TICKS) && (m_hold == 0);
            t_lvl = m_mode ? rx_pol : 1;
            if (t_chg) begin n_s1 = t_lvl; n_s2 = t_lvl; end
            else begin n_s1 = t_rx; n_s2 = m_s1; end
            if (!m_mode || t_chg) n_hold = 0;
            else if (tick_en) n_hold = ((m_s2 ^ rx_pol) != 0) ? OSR : (m_hold > 0 ? m_hold - 1 : 0);
            else n_hold = m_hold;
            n_mode = soft_rst ? ir_strap : (t_li ? m_req : m_mode);
            n_req  = soft_rst ? ir_strap : (ir_wr ? ir_wr_val : m_req);
            if (tick_en) begin
                t_cur = (uart_tx_bit != m_last) ? 0 : (m_phase + 1) % OSR;
                m_phase = t_cur;
                m_last = uart_tx_bit;
                m_enc = (!uart_tx_bit && t_cur >= PSTART && t_cur < PSTART + PW);
                m_idle = uart_tx_bit ? ((m_idle < IDLE_TICKS) ? m_idle + 1 : IDLE_TICKS) : 0;
            end
            m_s1 = n_s1; m_s2 = n_s2; m_hold = n_hold; m_mode = n_mode; m_req = n_req;
        end
    end

    // Compare the design to the model every cycle, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(line_tx == ((m_mode != 0) ? m_enc[0] : uart_tx_bit), cur_req, "line_tx vs model",
                line_tx, (m_mode != 0) ? m_enc : uart_tx_bit);
            chk(uart_rx_bit == ((m_mode != 0) ? (m_hold == 0) : m_s2[0]), cur_req, "uart_rx_bit vs model",
                uart_rx_bit, (m_mode != 0) ? (m_hold == 0) : m_s2);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
        for (int g = 0; g < gap; g++) step();
    endtask

    task automatic idle_ticks(input int n);
        uart_tx_bit = 1'b1;
        for (int i = 0; i < n; i++) tick();
    endtask

    // Send one frame (start, 8 data LSB first, stop); check pulses and loopback.
    task automatic send_byte(input logic [7:0] b, input bit ir, input string rq_w, input string rq_d);
        logic [9:0] frame;
        logic [9:0] got;
        frame = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            int highs;
            int first;
            highs = 0; first = -1;
            uart_tx_bit = frame[i];
            for (int k = 0; k < OSR; k++) begin
                tick();
                if (line_tx) begin
                    highs++;
                    if (first < 0) first = k;
                end
                if (k == 14) got[i] = uart_rx_bit;
            end
            if (ir) begin
                chk(highs == (frame[i] ? 0 : PW), frame[i] ? "R4" : rq_w, "pulse ticks in cell",
                    highs, frame[i] ? 0 : PW);
                if (!frame[i]) chk(first == PSTART, rq_w, "pulse start phase", first, PSTART);
            end
        end
        chk(got[8:1] == b, rq_d, "recovered byte", got[8:1], b);
    endtask

    initial begin
        // Reset with strap low: wired mode, line idles high (R8).
        cur_req = "R8";
        rst_n = 1'b0; ir_strap = 1'b0;
        repeat (3) step();
        cmp_on = 1'b1;
        chk(line_tx == 1'b1, "R8", "line_tx in reset, strap 0", line_tx, 1);
        chk(uart_rx_bit == 1'b1, "R8", "uart_rx_bit in reset", uart_rx_bit, 1);
        rst_n = 1'b1;
        step();

        // R1: wired pass-through on both paths.
        cur_req = "R1";
        for (int i = 0; i < 4; i++) begin
            uart_tx_bit = i[0];
            rx_drv = i[1];
            step();
            chk(line_tx == uart_tx_bit, "R1", "line_tx follows uart_tx_bit", line_tx, uart_tx_bit);
            step();
            chk(uart_rx_bit == rx_drv, "R1", "uart_rx_bit two edges later", uart_rx_bit, rx_drv);
        end
        rx_drv = 1'b1;
        uart_tx_bit = 1'b1;
        loop_en = 1'b1;
        send_byte(8'h3C, 1'b0, "R1", "R1");

        // R10: request infrared mode on a quiet line; applies one edge later.
        cur_req = "R10";
        idle_ticks(IDLE_TICKS);
        ir_wr = 1'b1; ir_wr_val = 1'b1;
        step();
        ir_wr = 1'b0;
        step();
        chk(line_tx == 1'b0, "R10", "infrared idle level after quiet write", line_tx, 0);

        // R3/R4/R5: infrared loopback with high-going pulses.
        cur_req = "R5";
        send_byte(8'h55, 1'b1, "R3", "R5");
        send_byte(8'hA3, 1'b1, "R3", "R5");
        send_byte(8'h00, 1'b1, "R3", "R5");

        // R7 and R2: a quiet line keeps the receive bit at one and transmit low.
        cur_req = "R7";
        idle_ticks(40);
        chk(uart_rx_bit == 1'b1, "R7", "rx bit with no pulses", uart_rx_bit, 1);
        chk(line_tx == 1'b0, "R2", "line_tx idle in infrared mode", line_tx, 0);

        // R6/R11: low-going pulses, ticks every other clock.
        cur_req = "R6";
        rx_pol = 1'b1;
        gap = 1;
        idle_ticks(30);
        send_byte(8'hC6, 1'b1, "R11", "R6");
        send_byte(8'h0F, 1'b1, "R11", "R6");
        gap = 0;
        idle_ticks(30);

        // R10: a write in mid frame is held off until the line is quiet.
        cur_req = "R10";
        uart_tx_bit = 1'b0;
        for (int k = 0; k < OSR; k++) tick();
        ir_wr = 1'b1; ir_wr_val = 1'b0;
        step();
        ir_wr = 1'b0;
        uart_tx_bit = 1'b1;
        for (int k = 0; k < OSR; k++) begin
            tick();
            if (k == 10) chk(line_tx == 1'b0, "R10", "one bit still dark mid frame", line_tx, 0);
        end
        uart_tx_bit = 1'b0;
        for (int k = 0; k < OSR; k++) tick();
        idle_ticks(IDLE_TICKS - 1);
        chk(line_tx == 1'b0, "R10", "mode held one tick before quiet", line_tx, 0);
        tick();
        chk(line_tx == 1'b0, "R10", "mode held on the quiet tick", line_tx, 0);
        step();
        chk(line_tx == 1'b1, "R10", "wired mode once quiet", line_tx, 1);

        // R9: soft reset loads the strap at once and also resets the request.
        cur_req = "R9";
        ir_strap = 1'b1;
        uart_tx_bit = 1'b1;
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk(line_tx == 1'b0, "R9", "infrared after soft reset", line_tx, 0);
        idle_ticks(IDLE_TICKS + 2);
        chk(line_tx == 1'b0, "R9", "request reloaded with mode", line_tx, 0);

        // R8: hardware reset with the strap high, then low.
        cur_req = "R8";
        rst_n = 1'b0;
        repeat (3) step();
        chk(line_tx == 1'b0, "R8", "line_tx in reset, strap 1", line_tx, 0);
        chk(uart_rx_bit == 1'b1, "R8", "uart_rx_bit in reset, strap 1", uart_rx_bit, 1);
        ir_strap = 1'b0;
        repeat (3) step();
        chk(line_tx == 1'b1, "R8", "line_tx in reset, strap 0 again", line_tx, 1);
        rst_n = 1'b1;
        repeat (4) step();

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule